// File: doc/BRIEF.md
# System-Control Coprocessor: Exception and Mode Controller

This block is the privileged-state keeper of a 32-bit load/store core with a single-issue pipeline. It holds the processor status word, the exception cause, the exception return address, the faulting-address register and the page/segment part of the translation-entry-high register. When the pipeline reports a trap, the block saves the state needed to resume and switches the core into kernel mode with interrupts and address translation off. In the same clock edge it pushes the previous mode onto a small three-level stack, records why the trap happened and issues a one-cycle jump request to the handler entry point.

The pipeline drives it with a trap request, a trap code, the PC of the trapping instruction, a delay-slot flag, the offending virtual address and a coprocessor number. Kernel code reads the registers through a selector port and writes them through a move-to port. A return-from-exception strobe pops the mode stack. Six external interrupt lines and two software bits are combined into a pending field. The block raises an interrupt-taken request when a pending line is enabled by the mask and the global enable is on. The pipeline answers that request by reporting a trap with code 0.

Register selectors on both the read and the write port are 0 status, 1 cause, 2 return address, 3 faulting address and 4 translation-entry-high. Any other selector reads as zero and writes nothing.

Top module: `cp0_ctrl`

## Requirements
- R1: Reset leaves the status register reading 0x10400000: bit 28 (coprocessor 0 usable) and bit 22 (boot vector select) are 1, and every mode stack bit is 0, which means kernel mode (kernel/user bit 0 = kernel, 1 = user), interrupts off and translation off. The cause, return address, faulting address and entry-high registers read 0. In the first cycle after reset, redirect_en is 1 with redirect_pc = 0x1FC00000.
- R2: A trap pushes three stacks in status in one edge. The interrupt-enable stack uses bits 0/2/4 (current/previous/old) and the kernel/user stack uses bits 1/3/5. The translation stack uses bits 24/25/26. On the push, old takes previous, previous takes current and current becomes 0. kernel_mode shows the inverse of bit 1 and vm_on shows bit 24.
- R3: A trap writes its code into cause bits 6:2 and the trapping PC into the return-address register. The code values are interrupt 0, page-modify 1, TLB load 2, TLB store 3, load address error 4, store address error 5, instruction bus error 6, data bus error 7, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11 and overflow 12.
- R4: A trap flagged as being in a branch delay slot sets cause bit 31 and stores the trapping PC minus 4 as the return address. A trap without the flag clears bit 31.
- R5: The edge after a trap, redirect_en is 1 for one cycle. redirect_pc is 0x1FC00180 if status bit 22 was 1 at the trap, and 0x00000080 if it was 0.
- R6: Traps with codes 1 to 5 copy exc_vaddr into the faulting-address register. Every other code leaves that register unchanged.
- R7: Traps with codes 1 to 3 load entry-high bits 31:12 (segment number and virtual page) from exc_vaddr bits 31:12 and leave the address-space id in bits 11:6 unchanged. Other codes leave entry-high unchanged.
- R8: A trap with code 11 writes exc_cop into cause bits 29:28. Any other trap clears those bits.
- R9: Cause bits 15:10 follow hw_irq one edge later, and cause bits 9:8 are software bits set by a cause write. irq_take is 1 exactly when some cause bit 15:8 is set with the matching status bit 15:8 set, and status bit 0 is 1.
- R10: A return-from-exception strobe with no trap in the same cycle copies previous to current and old to previous in all three stacks, and leaves the old bits unchanged.
- R11: A status write changes only bits 31:28, 26:24, 22, 15:8 and 5:0. A cause write changes only bits 9:8. An entry-high write changes only bits 31:6. Writes to the return-address and faulting-address registers are ignored. In one cycle a trap wins over a return strobe, which wins over a register write, and the lower-priority action is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | Trap taken this cycle |
| exc_code | input | 5 | Trap code |
| exc_pc | input | 32 | PC of the trapping instruction |
| exc_in_delay | input | 1 | Trapping instruction sits in a branch delay slot |
| exc_vaddr | input | 32 | Offending virtual address |
| exc_cop | input | 2 | Coprocessor number for an unusable-coprocessor trap |
| hw_irq | input | 6 | External interrupt lines |
| mt_en | input | 1 | Register write strobe |
| mt_sel | input | 3 | Register write selector |
| mt_data | input | 32 | Register write data |
| mf_sel | input | 3 | Register read selector |
| mf_data | output | 32 | Register read data (combinational) |
| rfe | input | 1 | Return-from-exception strobe |
| redirect_en | output | 1 | Jump request to redirect_pc |
| redirect_pc | output | 32 | Jump target |
| kernel_mode | output | 1 | Core is in kernel mode |
| vm_on | output | 1 | Address translation enabled |
| irq_take | output | 1 | An enabled interrupt is pending |

## Verification
On every cycle the assertions check the stack push on a trap and the pop on a return strobe. They also check the vector chosen from the boot bit, the minus-4 return address for delay-slot traps, the address-space id being left alone across traps, and that irq_take never rises while the global enable is off. The bench scenarios are what show the rest. They cover the write masks and the ignored writes, the priority when a trap, a return strobe and a write meet in one cycle, and the code-dependent capture of the faulting address, the entry-high fields and the coprocessor number. They also cover the one-cycle delay from the interrupt lines to the pending field and the exact reset values.

// File: rtl/cp0_pkg.sv
package cp0_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned HW_IRQ_N  = 6;
    localparam int unsigned SW_IRQ_N  = 2;
    localparam int unsigned IP_W      = HW_IRQ_N + SW_IRQ_N;
    localparam int unsigned IP_LSB    = 8;
    localparam int unsigned HW_LSB    = IP_LSB + SW_IRQ_N;
    localparam int unsigned IM_LSB    = 8;
    localparam int unsigned VM_BASE   = 24;
    localparam int unsigned BEV_BIT   = 22;
    localparam int unsigned KU_BIT    = 1;
    localparam int unsigned IE_BIT    = 0;
    localparam int unsigned BD_BIT    = 31;
    localparam int unsigned CE_LSB    = 28;
    localparam int unsigned CODE_LSB  = 2;
    localparam int unsigned PAGE_LSB  = 12;
    localparam int unsigned STK_FIELDS = 3;
    localparam int unsigned STK_DEPTH  = 3;

    localparam logic [XLEN-1:0] STATUS_RST  = 32'h1040_0000;
    localparam logic [XLEN-1:0] STATUS_WMSK = 32'hF740_FF3F;
    localparam logic [XLEN-1:0] CAUSE_WMSK  = 32'h0000_0300;
    localparam logic [XLEN-1:0] EHI_WMSK    = 32'hFFFF_FFC0;

    typedef enum logic [4:0] {
        EXC_INT  = 5'd0,
        EXC_MOD  = 5'd1,
        EXC_TLBL = 5'd2,
        EXC_TLBS = 5'd3,
        EXC_ADEL = 5'd4,
        EXC_ADES = 5'd5,
        EXC_IBE  = 5'd6,
        EXC_DBE  = 5'd7,
        EXC_SYS  = 5'd8,
        EXC_BP   = 5'd9,
        EXC_RI   = 5'd10,
        EXC_CPU  = 5'd11,
        EXC_OV   = 5'd12
    } exc_code_e;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_CAUSE  = 3'd1,
        SEL_EPC    = 3'd2,
        SEL_BADV   = 3'd3,
        SEL_EHI    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] badv;
        logic [XLEN-1:0] ehi;
        logic            redir_en;
        logic [XLEN-1:0] redir_pc;
    } cp0_state_t;

    // field 0 = interrupt enable, 1 = kernel/user, 2 = translation; level 0 = current
    function automatic int unsigned stk_bit(int unsigned field, int unsigned level);
        return (field == 2) ? VM_BASE + level : 2 * level + field;
    endfunction

endpackage

// File: rtl/cp0_mode_stack.sv
module cp0_mode_stack #(
    parameter int unsigned DEPTH = 3
) (
    input  logic [DEPTH-1:0] cur,
    input  logic             push,
    input  logic             pop,
    output logic [DEPTH-1:0] nxt
);
    // bit 0 is current, DEPTH-1 is the oldest level
    always_comb begin
        nxt = cur;
        if (push) begin
            nxt = {cur[DEPTH-2:0], 1'b0};
        end else if (pop) begin
            nxt = {cur[DEPTH-1], cur[DEPTH-1:1]};
        end
    end
endmodule

// File: rtl/cp0_exc_decode.sv
module cp0_exc_decode
    import cp0_pkg::*;
(
    input  logic [4:0]      code,
    input  logic [XLEN-1:0] pc,
    input  logic            in_delay,
    output logic            cap_badv,
    output logic            cap_ehi,
    output logic            is_cpu,
    output logic [XLEN-1:0] epc_val
);
    always_comb begin
        cap_ehi  = (code == EXC_MOD) || (code == EXC_TLBL) || (code == EXC_TLBS);
        cap_badv = cap_ehi || (code == EXC_ADEL) || (code == EXC_ADES);
        is_cpu   = (code == EXC_CPU);
        epc_val  = in_delay ? (pc - XLEN'(4)) : pc;
    end
endmodule

// File: rtl/cp0_irq_gate.sv
module cp0_irq_gate #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] pending,
    input  logic [N-1:0] mask,
    input  logic         enable,
    output logic         take
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign hit[i] = pending[i] & mask[i];
    end

    assign take = enable & (|hit);
endmodule

// File: rtl/cp0_vec_sel.sv
module cp0_vec_sel
    import cp0_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_VEC = 32'h1FC0_0180,
    parameter logic [XLEN-1:0] NORM_VEC = 32'h0000_0080
) (
    input  logic            bev,
    output logic [XLEN-1:0] vec
);
    assign vec = bev ? BOOT_VEC : NORM_VEC;
endmodule

// File: rtl/cp0_ctrl.sv
module cp0_ctrl
    import cp0_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h1FC0_0000,
    parameter logic [XLEN-1:0] BOOT_VEC = 32'h1FC0_0180,
    parameter logic [XLEN-1:0] NORM_VEC = 32'h0000_0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exc_req,
    input  logic [4:0]          exc_code,
    input  logic [XLEN-1:0]     exc_pc,
    input  logic                exc_in_delay,
    input  logic [XLEN-1:0]     exc_vaddr,
    input  logic [1:0]          exc_cop,
    input  logic [HW_IRQ_N-1:0] hw_irq,
    input  logic                mt_en,
    input  logic [2:0]          mt_sel,
    input  logic [XLEN-1:0]     mt_data,
    input  logic [2:0]          mf_sel,
    output logic [XLEN-1:0]     mf_data,
    input  logic                rfe,
    output logic                redirect_en,
    output logic [XLEN-1:0]     redirect_pc,
    output logic                kernel_mode,
    output logic                vm_on,
    output logic                irq_take
);
    cp0_state_t st_d, st_q;

    logic [XLEN-1:0] status_q, cause_q, epc_q, badv_q, ehi_q;
    assign status_q = st_q.status;
    assign cause_q  = st_q.cause;
    assign epc_q    = st_q.epc;
    assign badv_q   = st_q.badv;
    assign ehi_q    = st_q.ehi;

    logic [STK_FIELDS-1:0][STK_DEPTH-1:0] stk_cur, stk_nxt;
    logic            pop;
    logic            cap_badv, cap_ehi, is_cpu;
    logic [XLEN-1:0] epc_val, vec;

    assign pop = rfe & ~exc_req;

    for (genvar f = 0; f < STK_FIELDS; f++) begin : g_stack
        for (genvar l = 0; l < STK_DEPTH; l++) begin : g_level
            assign stk_cur[f][l] = status_q[stk_bit(f, l)];
        end
        cp0_mode_stack #(.DEPTH(STK_DEPTH)) u_stack (
            .cur  (stk_cur[f]),
            .push (exc_req),
            .pop  (pop),
            .nxt  (stk_nxt[f])
        );
    end

    cp0_exc_decode u_decode (
        .code     (exc_code),
        .pc       (exc_pc),
        .in_delay (exc_in_delay),
        .cap_badv (cap_badv),
        .cap_ehi  (cap_ehi),
        .is_cpu   (is_cpu),
        .epc_val  (epc_val)
    );

    cp0_vec_sel #(.BOOT_VEC(BOOT_VEC), .NORM_VEC(NORM_VEC)) u_vec (
        .bev (status_q[BEV_BIT]),
        .vec (vec)
    );

    cp0_irq_gate #(.N(IP_W)) u_irq (
        .pending (cause_q[IP_LSB +: IP_W]),
        .mask    (status_q[IM_LSB +: IP_W]),
        .enable  (status_q[IE_BIT]),
        .take    (irq_take)
    );

    always_comb begin
        logic wr;
        st_d = st_q;
        st_d.redir_en = 1'b0;
        st_d.cause[HW_LSB +: HW_IRQ_N] = hw_irq;
        wr = mt_en & ~exc_req & ~rfe;

        if (wr) begin
            case (mt_sel)
                SEL_STATUS: st_d.status = (st_q.status & ~STATUS_WMSK) | (mt_data & STATUS_WMSK);
                SEL_CAUSE:  st_d.cause[IP_LSB +: SW_IRQ_N] = mt_data[IP_LSB +: SW_IRQ_N];
                SEL_EHI:    st_d.ehi = (st_q.ehi & ~EHI_WMSK) | (mt_data & EHI_WMSK);
                default: ;
            endcase
        end

        if (exc_req || rfe) begin
            for (int f = 0; f < STK_FIELDS; f++) begin
                for (int l = 0; l < STK_DEPTH; l++) begin
                    st_d.status[stk_bit(f, l)] = stk_nxt[f][l];
                end
            end
        end

        if (exc_req) begin
            st_d.epc                  = epc_val;
            st_d.cause[BD_BIT]        = exc_in_delay;
            st_d.cause[CE_LSB +: 2]   = is_cpu ? exc_cop : 2'b00;
            st_d.cause[CODE_LSB +: 5] = exc_code;
            if (cap_badv) st_d.badv = exc_vaddr;
            if (cap_ehi)  st_d.ehi[XLEN-1:PAGE_LSB] = exc_vaddr[XLEN-1:PAGE_LSB];
            st_d.redir_en = 1'b1;
            st_d.redir_pc = vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.status   <= STATUS_RST;
            st_q.redir_en <= 1'b1;
            st_q.redir_pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (mf_sel)
            SEL_STATUS: mf_data = status_q;
            SEL_CAUSE:  mf_data = cause_q;
            SEL_EPC:    mf_data = epc_q;
            SEL_BADV:   mf_data = badv_q;
            SEL_EHI:    mf_data = ehi_q;
            default:    mf_data = '0;
        endcase
    end

    assign redirect_en = st_q.redir_en;
    assign redirect_pc = st_q.redir_pc;
    assign kernel_mode = ~status_q[KU_BIT];
    assign vm_on       = status_q[VM_BASE];
endmodule

// File: rtl/cp0_ctrl_chk.sv
module cp0_ctrl_chk
    import cp0_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_VEC = 32'h1FC0_0180,
    parameter logic [XLEN-1:0] NORM_VEC = 32'h0000_0080
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_req,
    input logic [XLEN-1:0] exc_pc,
    input logic            exc_in_delay,
    input logic            rfe,
    input logic [XLEN-1:0] status_q,
    input logic [XLEN-1:0] epc_q,
    input logic [XLEN-1:0] ehi_q,
    input logic            redirect_en,
    input logic [XLEN-1:0] redirect_pc,
    input logic            irq_take
);
    p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> redirect_en &&
                    redirect_pc == ($past(status_q[BEV_BIT]) ? BOOT_VEC : NORM_VEC));

    p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> status_q[1:0] == 2'b00 &&
                    status_q[3:2] == $past(status_q[1:0]) &&
                    status_q[5:4] == $past(status_q[3:2]) &&
                    status_q[26:24] == {$past(status_q[25:24]), 1'b0});

    p_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !exc_req) |=> status_q[1:0] == $past(status_q[3:2]) &&
                              status_q[3:2] == $past(status_q[5:4]) &&
                              $stable(status_q[5:4]) &&
                              status_q[25:24] == $past(status_q[26:25]) &&
                              $stable(status_q[26]));

    p_delay_epc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_in_delay) |=> epc_q == $past(exc_pc) - 32'd4);

    p_asid_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> $stable(ehi_q[11:6]));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> status_q[IE_BIT]);
endmodule

bind cp0_ctrl cp0_ctrl_chk #(.BOOT_VEC(BOOT_VEC), .NORM_VEC(NORM_VEC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_req      (exc_req),
    .exc_pc       (exc_pc),
    .exc_in_delay (exc_in_delay),
    .rfe          (rfe),
    .status_q     (status_q),
    .epc_q        (epc_q),
    .ehi_q        (ehi_q),
    .redirect_en  (redirect_en),
    .redirect_pc  (redirect_pc),
    .irq_take     (irq_take)
);

// File: tb/test_cp0_ctrl.sv
`timescale 1ns/1ps
module test_cp0_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic        exc_in_delay = 1'b0;
    logic [31:0] exc_vaddr = '0;
    logic [1:0]  exc_cop = '0;
    logic [5:0]  hw_irq = '0;
    logic        mt_en = 1'b0;
    logic [2:0]  mt_sel = '0;
    logic [31:0] mt_data = '0;
    logic [2:0]  mf_sel = '0;
    logic [31:0] mf_data;
    logic        rfe = 1'b0;
    logic        redirect_en;
    logic [31:0] redirect_pc;
    logic        kernel_mode, vm_on, irq_take;

    always #10 clk = ~clk;

    cp0_ctrl i_cp0_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .exc_vaddr(exc_vaddr),
        .exc_cop(exc_cop), .hw_irq(hw_irq), .mt_en(mt_en), .mt_sel(mt_sel),
        .mt_data(mt_data), .mf_sel(mf_sel), .mf_data(mf_data), .rfe(rfe),
        .redirect_en(redirect_en), .redirect_pc(redirect_pc),
        .kernel_mode(kernel_mode), .vm_on(vm_on), .irq_take(irq_take)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    int    rot = 0;
    bit    finished = 0;
    string tag = "R1";

    // reference state
    logic [31:0] m_st, m_ca, m_epc, m_bad, m_ehi, m_rpc;
    logic        m_ren;

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [2:0] s);
        case (s)
            3'd0: return m_st;
            3'd1: return m_ca;
            3'd2: return m_epc;
            3'd3: return m_bad;
            3'd4: return m_ehi;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        return m_st[0] && ((m_ca[15:8] & m_st[15:8]) != 8'h00);
    endfunction

    task automatic m_reset();
        m_st = 32'h1040_0000; m_ca = 0; m_epc = 0; m_bad = 0; m_ehi = 0;
        m_ren = 1; m_rpc = 32'h1FC0_0000;
    endtask

    task automatic m_step();
        logic [31:0] s, c;
        s = m_st; c = m_ca;
        m_ren = 0;
        c[15:10] = hw_irq;
        if (exc_req) begin
            s[5] = m_st[3]; s[3] = m_st[1]; s[1] = 0;
            s[4] = m_st[2]; s[2] = m_st[0]; s[0] = 0;
            s[26] = m_st[25]; s[25] = m_st[24]; s[24] = 0;
            m_epc = exc_in_delay ? exc_pc - 4 : exc_pc;
            c[31] = exc_in_delay;
            c[29:28] = (exc_code == 5'd11) ? exc_cop : 2'b00;
            c[6:2] = exc_code;
            if (exc_code >= 1 && exc_code <= 5) m_bad = exc_vaddr;
            if (exc_code >= 1 && exc_code <= 3) m_ehi[31:12] = exc_vaddr[31:12];
            m_ren = 1;
            m_rpc = m_st[22] ? 32'h1FC0_0180 : 32'h0000_0080;
        end else if (rfe) begin
            s[1:0] = m_st[3:2]; s[3:2] = m_st[5:4];
            s[24] = m_st[25]; s[25] = m_st[26];
        end else if (mt_en) begin
            case (mt_sel)
                3'd0: s = (m_st & ~32'hF740_FF3F) | (mt_data & 32'hF740_FF3F);
                3'd1: c[9:8] = mt_data[9:8];
                3'd4: m_ehi = (m_ehi & 32'h0000_003F) | (mt_data & 32'hFFFF_FFC0);
                default: ;
            endcase
        end
        m_st = s; m_ca = c;
    endtask

    // called right after a falling edge with inputs set
    task automatic tick();
        mf_sel = 3'(rot % 6);
        rot++;
        #5;
        check("redirect_en", {31'b0, redirect_en}, {31'b0, m_ren});
        check("redirect_pc", redirect_pc, m_rpc);
        check("kernel_mode", {31'b0, kernel_mode}, {31'b0, ~m_st[1]});
        check("vm_on", {31'b0, vm_on}, {31'b0, m_st[24]});
        check("irq_take", {31'b0, irq_take}, {31'b0, m_irq()});
        check($sformatf("mf_data sel%0d", mf_sel), mf_data, m_read(mf_sel));
        @(posedge clk);
        m_step();
        @(negedge clk);
        exc_req = 0; rfe = 0; mt_en = 0; exc_in_delay = 0;
    endtask

    task automatic trap(logic [4:0] code, logic [31:0] pc, logic dly,
                        logic [31:0] va, logic [1:0] cop);
        exc_req = 1; exc_code = code; exc_pc = pc; exc_in_delay = dly;
        exc_vaddr = va; exc_cop = cop;
        tick();
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        mt_en = 1; mt_sel = sel; mt_data = d;
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        m_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1: reset values and boot redirect
        tag = "R1";
        idle(7);

        // R11: write masks, then read-only registers
        tag = "R11";
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd0, 32'h1040_FF00 | 32'h0100_0003);
        wr(3'd2, 32'hDEAD_BEEF);
        wr(3'd3, 32'hCAFE_F00D);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd4, 32'h0000_0A80);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0);
        idle(6);

        // R2 R3 R5: syscall from user mode with translation on, boot vector
        tag = "R3";
        trap(5'd8, 32'h0040_1000, 0, 32'h1234_5678, 2'd0);
        tag = "R5";
        idle(6);

        // R4: clear boot bit, trap in a delay slot, normal vector
        tag = "R4";
        wr(3'd0, 32'h1000_FF00);
        trap(5'd9, 32'h0040_2008, 1, 32'h0, 2'd0);
        idle(6);

        // R6 R7: TLB load miss keeps ASID, address error only captures address
        tag = "R7";
        wr(3'd4, 32'h0000_0FC0);
        trap(5'd2, 32'h0040_3000, 0, 32'h8765_4321, 2'd0);
        idle(6);
        tag = "R6";
        trap(5'd5, 32'h0040_3004, 0, 32'hABCD_0003, 2'd0);
        idle(6);
        trap(5'd7, 32'h0040_3008, 0, 32'h5555_AAAA, 2'd0);
        idle(6);

        // R8: unusable coprocessor number, then cleared by another trap
        tag = "R8";
        trap(5'd11, 32'h0040_4000, 0, 32'h0, 2'd1);
        idle(6);
        trap(5'd10, 32'h0040_4004, 0, 32'h0, 2'd3);
        idle(6);

        // R10: pops with old bits kept
        tag = "R10";
        wr(3'd0, 32'h1100_FF15);
        rfe = 1; tick();
        idle(6);
        rfe = 1; tick();
        idle(6);

        // R9: interrupt gating, hardware and software pending bits
        tag = "R9";
        wr(3'd0, 32'h1000_0400);
        hw_irq = 6'b000001;
        idle(6);
        wr(3'd0, 32'h1000_0401);
        idle(6);
        wr(3'd0, 32'h1000_0801);
        idle(3);
        hw_irq = 6'b0;
        wr(3'd1, 32'h0000_0200);
        idle(6);
        trap(5'd0, 32'h0040_5000, 0, 32'h0, 2'd0);
        idle(6);

        // R11: priority of trap over return over write
        tag = "R11";
        wr(3'd0, 32'h1000_0013);
        exc_req = 1; exc_code = 5'd12; exc_pc = 32'h0040_6000;
        rfe = 1; mt_en = 1; mt_sel = 3'd0; mt_data = 32'hFFFF_FFFF;
        tick();
        idle(6);
        rfe = 1; mt_en = 1; mt_sel = 3'd4; mt_data = 32'hFFFF_FFFF;
        tick();
        idle(6);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule